// File: doc/BRIEF.md
# Packet Write-Back Commit Queue

This block sits beside the execute stage of a processor that issues instructions in parallel packets. While a packet executes, each instruction pushes its results (register writes and program-counter writes) into a small queue instead of updating state at once. When the packet ends, a commit strobe starts a walk that replays the queue in push order, one entry per clock. The walk sends register writes out as a serial stream and resolves the next program counter.

Two filters act during the walk. Only the first surviving PC write in a packet is honoured, so a later branch in the same packet has no effect. If an imprecise exception has been recorded, the entries pushed by the faulting instruction are screened. Entries from every other instruction pass untouched. For a floating-point fault, the faulting instruction's entries survive only when the fault mask shows nothing worse than inexact, underflow or overflow. For any other fault, they survive only when the entry carries its forced flag. While an entry is being replayed, its originating instruction address is shown as the attribution PC, so a fault raised by that write is charged to the right instruction.

When the walk ends, a one-cycle done pulse carries the next PC. A pending link request is also served in that cycle: the fall-through PC captured at the commit strobe is written to the link register.

Top module: `pwq_top`

## Requirements
- R1: After reset, full, enq_err, busy, wr_valid, done, next_pc_valid and link_we are all low.
- R2: While idle, enq_valid appends one entry per cycle (enq_kind 0 = register write, 1 = PC write). full is high once DEPTH (default 8) entries are held. An enqueue while full is dropped, and enq_err is high in the following cycle.
- R3: pkt_start while idle empties the queue and clears the exception record and the link request. A commit strobe in the same cycle as pkt_start is ignored.
- R4: A commit strobe while idle latches cur_pc as the fall-through PC. Starting the next cycle, one entry per cycle is replayed in push order, with busy high. A surviving register entry drives wr_valid with its target and value, and attr_pc equals the replayed entry's instruction address.
- R5: Only the first surviving PC-write entry of a walk sets the branch target. Later PC writes change nothing, and PC entries never drive wr_valid.
- R6: With a non-floating-point exception recorded (exc_is_fp = 0), an entry whose address equals exc_iaddr survives only if its forced flag is set.
- R7: With a floating-point exception recorded, an entry at exc_iaddr survives only when exc_mask has no bit set outside bits [2:0] (the benign inexact, underflow and overflow bits). The forced flag is not consulted in this case.
- R8: Entries whose address differs from the recorded fault address always survive.
- R9: done and next_pc_valid pulse for one cycle, in the cycle after the last replayed entry, or in the cycle after the strobe when the queue is empty. next_pc is the first branch target if one was taken, and otherwise the fall-through PC. The queue is empty afterwards.
- R10: If link_req was seen while idle, link_we is high in the done cycle, with link_value equal to the fall-through PC. The request is then cleared.
- R11: While busy, enq_valid, pkt_start, exc_set, link_req and commit have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pkt_start | input | 1 | Start of packet: empty queue and records |
| enq_valid | input | 1 | Push an entry |
| enq_kind | input | 1 | 0 register write, 1 PC write |
| enq_target | input | TW | Register index |
| enq_value | input | DW | Write data or branch target |
| enq_iaddr | input | AW | Address of the pushing instruction |
| enq_forced | input | 1 | Entry must survive a non-FP fault |
| full | output | 1 | Queue holds DEPTH entries |
| enq_err | output | 1 | Previous-cycle push was dropped |
| exc_set | input | 1 | Record an imprecise exception |
| exc_is_fp | input | 1 | Recorded fault is floating point |
| exc_iaddr | input | AW | Faulting instruction address |
| exc_mask | input | MW | Floating-point fault mask |
| link_req | input | 1 | Request a link-register update |
| commit | input | 1 | Commit strobe |
| cur_pc | input | AW | Fall-through PC sampled at commit |
| busy | output | 1 | Walk or done cycle in progress |
| wr_valid | output | 1 | Register write valid |
| wr_target | output | TW | Register write index |
| wr_value | output | DW | Register write data |
| attr_pc | output | AW | PC attributed to the current write |
| done | output | 1 | Walk finished pulse |
| next_pc_valid | output | 1 | next_pc valid |
| next_pc | output | AW | Resolved next PC |
| link_we | output | 1 | Link register write enable |
| link_value | output | AW | Link register data |

## Verification
The walk is tried first with plain register entries, which shows that order and attribution hold. A packet with two branches separates first-wins from last-wins. A queue filled to the brim with one extra push shows the drop. Fault packets mix faulting and clean instructions: forced and unforced entries under a non-FP fault tell the forced rule apart from a blanket drop, and benign versus non-benign FP masks show that the forced flag is ignored there. An empty commit, a pkt_start after pushes, and pushes and requests made while busy show that reset-like paths and ignored inputs leave no trace at the ports.

// File: rtl/pwq_pkg.sv
package pwq_pkg;
  typedef enum logic {WK_REG = 1'b0, WK_PC = 1'b1} wkind_e;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_WALK = 2'd1, ST_FIN = 2'd2} wstate_e;

  // survival rule for one entry under the recorded fault
  function automatic logic pwq_survives(input logic hit, input logic is_fp,
                                        input logic severe_bits, input logic forced);
    if (!hit) return 1'b1;
    if (is_fp) return !severe_bits;
    return forced;
  endfunction
endpackage

// File: rtl/pwq_store.sv
module pwq_store #(
  parameter int DEPTH = 8,
  parameter int TW = 6,
  parameter int DW = 32,
  parameter int AW = 32,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          push,
  input  logic          push_kind,
  input  logic [TW-1:0] push_target,
  input  logic [DW-1:0] push_value,
  input  logic [AW-1:0] push_iaddr,
  input  logic          push_forced,
  input  logic [IW-1:0] rd_idx,
  output logic          rd_kind,
  output logic [TW-1:0] rd_target,
  output logic [DW-1:0] rd_value,
  output logic [AW-1:0] rd_iaddr,
  output logic          rd_forced,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          drop_err
);
  logic          kind_q   [DEPTH];
  logic [TW-1:0] tgt_q    [DEPTH];
  logic [DW-1:0] val_q    [DEPTH];
  logic [AW-1:0] ia_q     [DEPTH];
  logic          forced_q [DEPTH];
  logic          push_ok;
  logic          push_drop;
  logic [IW-1:0] wr_ptr;

  assign full      = (count == CW'(DEPTH));
  assign push_ok   = push && !full && !clear;
  assign push_drop = push && full && !clear;
  assign wr_ptr    = IW'(count);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count    <= '0;
      drop_err <= 1'b0;
    end else begin
      drop_err <= push_drop;
      if (clear) count <= '0;
      else if (push_ok) count <= count + CW'(1);
    end
  end

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push_ok && wr_ptr == IW'(s)) begin
        kind_q[s]   <= push_kind;
        tgt_q[s]    <= push_target;
        val_q[s]    <= push_value;
        ia_q[s]     <= push_iaddr;
        forced_q[s] <= push_forced;
      end
    end
  end

  assign rd_kind   = kind_q[rd_idx];
  assign rd_target = tgt_q[rd_idx];
  assign rd_value  = val_q[rd_idx];
  assign rd_iaddr  = ia_q[rd_idx];
  assign rd_forced = forced_q[rd_idx];

  // R2
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  // R2
  drop_keeps_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_drop |=> $stable(count));
endmodule

// File: rtl/pwq_filter.sv
module pwq_filter #(
  parameter int AW = 32,
  parameter int MW = 5,
  parameter logic [MW-1:0] BENIGN = 5'b00111
) (
  input  logic          exc_valid,
  input  logic          exc_fp,
  input  logic [AW-1:0] exc_iaddr,
  input  logic [MW-1:0] exc_mask,
  input  logic [AW-1:0] ent_iaddr,
  input  logic          ent_forced,
  output logic          hit,
  output logic          keep
);
  import pwq_pkg::*;
  logic severe;
  assign hit    = exc_valid && (exc_iaddr == ent_iaddr);
  assign severe = |(exc_mask & ~BENIGN);
  assign keep   = pwq_survives(hit, exc_fp, severe, ent_forced);

  // R8
  foreign_entry_kept_chk: assert final (hit || keep);
endmodule

// File: rtl/pwq_ctl.sv
module pwq_ctl #(
  parameter int DEPTH = 8,
  parameter int AW = 32,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] count,
  input  logic          ent_is_pc,
  input  logic          ent_keep,
  input  logic [AW-1:0] ent_target_pc,
  output logic [IW-1:0] idx,
  output logic          in_walk,
  output logic          finish,
  output logic          busy,
  output logic          taken_q,
  output logic [AW-1:0] target_q
);
  import pwq_pkg::*;
  wstate_e st_q;
  logic    last_ent;
  logic    pc_take;

  assign in_walk  = (st_q == ST_WALK);
  assign finish   = (st_q == ST_FIN);
  assign busy     = (st_q != ST_IDLE);
  assign last_ent = (CW'(idx) == count - CW'(1));
  assign pc_take  = in_walk && ent_is_pc && ent_keep && !taken_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      idx      <= '0;
      taken_q  <= 1'b0;
      target_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (start) begin
          idx     <= '0;
          taken_q <= 1'b0;
          st_q    <= (count == '0) ? ST_FIN : ST_WALK;
        end
        ST_WALK: begin
          if (pc_take) begin
            taken_q  <= 1'b1;
            target_q <= ent_target_pc;
          end
          if (last_ent) st_q <= ST_FIN;
          else idx <= idx + IW'(1);
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R4
  walk_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_walk |-> (CW'(idx) < count));
  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> !busy);
  // R5
  target_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_walk && taken_q) |=> $stable(target_q));
endmodule

// File: rtl/pwq_top.sv
module pwq_top #(
  parameter int DEPTH = 8,
  parameter int TW = 6,
  parameter int DW = 32,
  parameter int AW = 32,
  parameter int MW = 5,
  parameter logic [MW-1:0] BENIGN = 5'b00111
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pkt_start,
  input  logic          enq_valid,
  input  logic          enq_kind,
  input  logic [TW-1:0] enq_target,
  input  logic [DW-1:0] enq_value,
  input  logic [AW-1:0] enq_iaddr,
  input  logic          enq_forced,
  output logic          full,
  output logic          enq_err,
  input  logic          exc_set,
  input  logic          exc_is_fp,
  input  logic [AW-1:0] exc_iaddr,
  input  logic [MW-1:0] exc_mask,
  input  logic          link_req,
  input  logic          commit,
  input  logic [AW-1:0] cur_pc,
  output logic          busy,
  output logic          wr_valid,
  output logic [TW-1:0] wr_target,
  output logic [DW-1:0] wr_value,
  output logic [AW-1:0] attr_pc,
  output logic          done,
  output logic          next_pc_valid,
  output logic [AW-1:0] next_pc,
  output logic          link_we,
  output logic [AW-1:0] link_value
);
  import pwq_pkg::*;
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic          pkt_clear, q_clear, start, push;
  logic          in_walk, finish, taken_q, ent_hit, ent_keep;
  logic [IW-1:0] idx;
  logic [CW-1:0] count;
  logic          e_kind, e_forced;
  logic [TW-1:0] e_target;
  logic [DW-1:0] e_value;
  logic [AW-1:0] e_iaddr, target_q;
  logic          exc_v_q, exc_fp_q, link_q;
  logic [AW-1:0] exc_ia_q, fall_pc_q;
  logic [MW-1:0] exc_mask_q;

  assign pkt_clear = pkt_start && !busy;
  assign start     = commit && !busy && !pkt_start;
  assign push      = enq_valid && !busy;
  assign q_clear   = pkt_clear || finish;

  pwq_store #(.DEPTH(DEPTH), .TW(TW), .DW(DW), .AW(AW)) store_i (
    .clk(clk), .rst_n(rst_n), .clear(q_clear), .push(push),
    .push_kind(enq_kind), .push_target(enq_target), .push_value(enq_value),
    .push_iaddr(enq_iaddr), .push_forced(enq_forced), .rd_idx(idx),
    .rd_kind(e_kind), .rd_target(e_target), .rd_value(e_value),
    .rd_iaddr(e_iaddr), .rd_forced(e_forced), .count(count), .full(full),
    .drop_err(enq_err));

  pwq_filter #(.AW(AW), .MW(MW), .BENIGN(BENIGN)) filter_i (
    .exc_valid(exc_v_q), .exc_fp(exc_fp_q), .exc_iaddr(exc_ia_q),
    .exc_mask(exc_mask_q), .ent_iaddr(e_iaddr), .ent_forced(e_forced),
    .hit(ent_hit), .keep(ent_keep));

  pwq_ctl #(.DEPTH(DEPTH), .AW(AW)) ctl_i (
    .clk(clk), .rst_n(rst_n), .start(start), .count(count),
    .ent_is_pc(e_kind == WK_PC), .ent_keep(ent_keep),
    .ent_target_pc(e_value[AW-1:0]), .idx(idx), .in_walk(in_walk),
    .finish(finish), .busy(busy), .taken_q(taken_q), .target_q(target_q));

  // packet-level records: fault, link request, fall-through pc
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exc_v_q    <= 1'b0;
      exc_fp_q   <= 1'b0;
      exc_ia_q   <= '0;
      exc_mask_q <= '0;
      link_q     <= 1'b0;
      fall_pc_q  <= '0;
    end else begin
      if (q_clear) exc_v_q <= 1'b0;
      else if (exc_set && !busy) begin
        exc_v_q    <= 1'b1;
        exc_fp_q   <= exc_is_fp;
        exc_ia_q   <= exc_iaddr;
        exc_mask_q <= exc_mask;
      end
      if (q_clear) link_q <= 1'b0;
      else if (link_req && !busy) link_q <= 1'b1;
      if (start) fall_pc_q <= cur_pc;
    end
  end

  assign wr_valid      = in_walk && (e_kind == WK_REG) && ent_keep;
  assign wr_target     = e_target;
  assign wr_value      = e_value;
  assign attr_pc       = in_walk ? e_iaddr : fall_pc_q;
  assign done          = finish;
  assign next_pc_valid = finish;
  assign next_pc       = taken_q ? target_q : fall_pc_q;
  assign link_we       = finish && link_q;
  assign link_value    = fall_pc_q;

  // R2
  full_push_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enq_valid && full && !busy && !pkt_start) |=> enq_err);
  // R11
  write_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> busy);
  // R6
  blocked_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_walk && ent_hit && !exc_fp_q && !e_forced) |-> !wr_valid);
  // R9
  queue_empty_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (count == '0));
  // R10
  link_in_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> done);
endmodule

// File: tb/pwq_top_tb_top.sv
module pwq_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pkt_start = 0, enq_valid = 0, enq_kind = 0, enq_forced = 0;
  logic [5:0] enq_target = '0;
  logic [31:0] enq_value = '0, enq_iaddr = '0, exc_iaddr = '0, cur_pc = '0;
  logic exc_set = 0, exc_is_fp = 0, link_req = 0, commit = 0;
  logic [4:0] exc_mask = '0;
  logic full, enq_err, busy, wr_valid, done, next_pc_valid, link_we;
  logic [5:0] wr_target;
  logic [31:0] wr_value, attr_pc, next_pc, link_value;

  always #2 clk = ~clk;

  pwq_top dut_i (.*);

  int total = 0, bad = 0;
  // bench-side model of the expected walk
  int m_n = 0;
  logic m_wv [9];
  logic [5:0] m_tg [9];
  logic [31:0] m_val [9];
  logic [31:0] m_ia [9];
  logic m_taken = 0;
  logic [31:0] m_tgt = '0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // push one entry; survive = bench's own verdict from R5..R8
  task automatic enq(logic kind, logic [5:0] tg, logic [31:0] v, logic [31:0] ia,
                     logic f, logic survive, logic record);
    enq_valid = 1; enq_kind = kind; enq_target = tg; enq_value = v;
    enq_iaddr = ia; enq_forced = f;
    tick();
    enq_valid = 0;
    if (record) begin
      m_wv[m_n] = (kind == 1'b0) && survive;
      m_tg[m_n] = tg; m_val[m_n] = v; m_ia[m_n] = ia;
      m_n++;
      if (kind && survive && !m_taken) begin
        m_taken = 1; m_tgt = v;
      end
    end
  endtask

  task automatic run_commit(string tag, logic [31:0] pc_in, logic exp_link);
    commit = 1; cur_pc = pc_in;
    tick();
    commit = 0;
    for (int i = 0; i < m_n; i++) begin
      chk({tag, " R4 wr_valid"}, wr_valid, m_wv[i]);
      if (m_wv[i]) begin
        chk({tag, " R4 target"}, wr_target, m_tg[i]);
        chk({tag, " R4 value"}, wr_value, m_val[i]);
      end
      chk({tag, " R4 attr_pc"}, attr_pc, m_ia[i]);
      chk({tag, " R4 busy"}, busy, 1);
      chk({tag, " R9 early done"}, done, 0);
      tick();
    end
    chk({tag, " R9 done"}, done, 1);
    chk({tag, " R9 next_pc_valid"}, next_pc_valid, 1);
    chk({tag, " R9 next_pc"}, next_pc, m_taken ? m_tgt : pc_in);
    chk({tag, " R10 link_we"}, link_we, exp_link);
    if (exp_link) chk({tag, " R10 link_value"}, link_value, pc_in);
    tick();
    chk({tag, " R9 done pulse"}, done, 0);
    chk({tag, " R9 idle"}, busy, 0);
    chk({tag, " R9 empty"}, full, 0);
    m_n = 0; m_taken = 0;
  endtask

  task automatic set_exc(logic fp, logic [31:0] ia, logic [4:0] mask);
    exc_set = 1; exc_is_fp = fp; exc_iaddr = ia; exc_mask = mask;
    tick();
    exc_set = 0;
  endtask

  task automatic new_packet();
    pkt_start = 1;
    tick();
    pkt_start = 0;
  endtask

  task automatic t_reset();
    chk("R1 full", full, 0);
    chk("R1 enq_err", enq_err, 0);
    chk("R1 busy", busy, 0);
    chk("R1 wr_valid", wr_valid, 0);
    chk("R1 done", done, 0);
    chk("R1 next_pc_valid", next_pc_valid, 0);
    chk("R1 link_we", link_we, 0);
  endtask

  task automatic t_plain();
    new_packet();
    enq(0, 6'd3, 32'h11, 32'h1000, 0, 1, 1);
    enq(0, 6'd7, 32'h22, 32'h1004, 0, 1, 1);
    enq(0, 6'd9, 32'h33, 32'h1008, 0, 1, 1);
    run_commit("plain", 32'h1010, 0);
  endtask

  task automatic t_two_branches();
    new_packet();
    enq(0, 6'd1, 32'hA1, 32'h2000, 0, 1, 1);
    enq(1, 6'd0, 32'h4000, 32'h2004, 0, 1, 1);
    enq(0, 6'd2, 32'hA2, 32'h2008, 0, 1, 1);
    enq(1, 6'd0, 32'h5000, 32'h200C, 0, 1, 1);
    chk("R5 model first target", m_tgt, 32'h4000);
    run_commit("R5 branches", 32'h2010, 0);
  endtask

  task automatic t_full();
    new_packet();
    for (int i = 0; i < 8; i++)
      enq(0, 6'(i + 10), 32'h100 + i, 32'h3000 + 4 * i, 0, 1, 1);
    chk("R2 full", full, 1);
    chk("R2 no err yet", enq_err, 0);
    enq(0, 6'd60, 32'hDEAD, 32'h3F00, 0, 1, 0);
    chk("R2 enq_err", enq_err, 1);
    chk("R2 still full", full, 1);
    run_commit("R2 full walk", 32'h3020, 0);
  endtask

  task automatic t_exc_plain();
    new_packet();
    set_exc(0, 32'h100, 5'b0);
    enq(0, 6'd1, 32'h11, 32'h100, 0, 0, 1);    // R6 unforced, dropped
    enq(0, 6'd2, 32'h22, 32'h100, 1, 1, 1);    // R6 forced, kept
    enq(1, 6'd0, 32'h500, 32'h100, 0, 0, 1);   // R6 branch dropped
    enq(0, 6'd3, 32'h33, 32'h104, 0, 1, 1);    // R8 other instruction
    enq(1, 6'd0, 32'h600, 32'h104, 0, 1, 1);   // R8 branch taken
    run_commit("R6 R8 nonfp fault", 32'h108, 0);
  endtask

  task automatic t_exc_fp();
    new_packet();
    set_exc(1, 32'h200, 5'b00101);
    enq(0, 6'd4, 32'h44, 32'h200, 0, 1, 1);    // R7 benign mask, kept
    enq(0, 6'd5, 32'h55, 32'h204, 0, 1, 1);
    run_commit("R7 benign", 32'h208, 0);
    new_packet();
    set_exc(1, 32'h300, 5'b01001);
    enq(0, 6'd6, 32'h66, 32'h300, 1, 0, 1);    // R7 severe, forced ignored
    enq(0, 6'd8, 32'h88, 32'h304, 0, 1, 1);    // R8
    run_commit("R7 severe", 32'h308, 0);
  endtask

  task automatic t_link();
    new_packet();
    link_req = 1; tick(); link_req = 0;
    enq(0, 6'd12, 32'hC0, 32'h700, 0, 1, 1);
    enq(1, 6'd0, 32'h900, 32'h704, 0, 1, 1);
    run_commit("R10 link", 32'h708, 1);
    run_commit("R10 flag cleared", 32'h708, 0);
  endtask

  task automatic t_empty_and_clear();
    new_packet();
    run_commit("R9 empty commit", 32'h800, 0);
    new_packet();
    set_exc(0, 32'h810, 5'b0);
    link_req = 1; tick(); link_req = 0;
    enq(0, 6'd13, 32'hD0, 32'h810, 0, 0, 0);
    new_packet();
    chk("R3 cleared", full, 0);
    enq(0, 6'd14, 32'hE0, 32'h810, 0, 1, 1);   // R3 fault record gone
    run_commit("R3 after clear", 32'h820, 0);
  endtask

  task automatic t_busy_ignore();
    new_packet();
    enq(0, 6'd20, 32'hF0, 32'hA00, 0, 1, 1);
    enq(0, 6'd21, 32'hF1, 32'hA04, 0, 1, 1);
    commit = 1; cur_pc = 32'hA08;
    tick();
    commit = 0;
    enq_valid = 1; enq_kind = 0; enq_target = 6'd30; enq_value = 32'hBAD;
    enq_iaddr = 32'hA00; link_req = 1; exc_set = 1; exc_is_fp = 0;
    exc_iaddr = 32'hA04; pkt_start = 1; commit = 1;
    chk("R11 wr0", wr_valid, 1);
    chk("R11 tg0", wr_target, 6'd20);
    tick();
    chk("R11 wr1", wr_valid, 1);
    chk("R11 tg1", wr_target, 6'd21);
    tick();
    enq_valid = 0; link_req = 0; exc_set = 0; pkt_start = 0; commit = 0;
    chk("R11 done", done, 1);
    chk("R11 no link", link_we, 0);
    chk("R11 next_pc", next_pc, 32'hA08);
    tick();
    chk("R11 queue empty", full, 0);
    m_n = 0; m_taken = 0;
    enq(0, 6'd22, 32'hF2, 32'hA04, 0, 1, 1);   // no fault recorded
    run_commit("R11 after busy", 32'hA10, 0);
  endtask

  logic finished = 0;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_plain();
    t_two_branches();
    t_full();
    t_exc_plain();
    t_exc_fp();
    t_link();
    t_empty_and_clear();
    t_busy_ignore();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule